// File: doc/BRIEF.md
# Opmask OR-Test Flag Unit

This block keeps eight 64-bit opmask registers and runs a mask test on them. A test names two registers and an operand width. The unit ORs the two masks over that width and reports the outcome on a set of status flags. The OR value itself is thrown away and never stored.

The width comes from two decode bits, a W bit and an operand-size prefix bit. The registers are loaded through a single write port. A write and a test may fall in the same cycle. If the write targets a register the test reads, the test sees the value being written.

Top module: `opmask_ortest`

## Requirements
- R1: A synchronous active-high reset clears all eight opmask registers, the six flags and `done` to 0.
- R2: The active width is set by {`w_bit`,`pfx`}: 00 gives 16 bits, 01 gives 8 bits, 10 gives 64 bits and 11 gives 32 bits. The width always starts at bit 0.
- R3: `zf` is 1 exactly when the OR of the two selected masks is zero over the active width.
- R4: `cf` is 1 exactly when that OR is all ones over the active width.
- R5: `of`, `sf`, `af` and `pf` read 0 after every test and after reset.
- R6: Bits above the active width in either source have no effect on `zf` or `cf`.
- R7: A test changes no register; only the flags change.
- R8: The flags update at the clock edge that samples `test_vld` high, and `done` is high for exactly the cycle after that edge. Without a test, the flags hold their values.
- R9: When a write and a test occur in the same cycle to the same index, the test uses the newly written value.
- R10: When `wr_en` is high, `wr_data` is stored into register `wr_idx` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register written |
| wr_data | input | 64 | Value written |
| test_vld | input | 1 | Start a mask test this cycle |
| src_a | input | 3 | First source register index |
| src_b | input | 3 | Second source register index |
| w_bit | input | 1 | Width decode bit W |
| pfx | input | 1 | Width decode bit, operand-size prefix |
| zf | output | 1 | OR result is zero |
| cf | output | 1 | OR result is all ones |
| of | output | 1 | Overflow flag, cleared by a test |
| sf | output | 1 | Sign flag, cleared by a test |
| af | output | 1 | Auxiliary flag, cleared by a test |
| pf | output | 1 | Parity flag, cleared by a test |
| done | output | 1 | One-cycle pulse after a test |

## Verification
A corrupted register can only be seen through the flags of a later test that reads it. The bench therefore keeps a shadow copy of all eight registers and follows every write with random tests over every width, so a wrong value shows up on the first test that touches it. A bad width decode or a faulty bypass shows up one cycle after the test as a wrong `zf` or `cf`. Directed cases place all-ones and all-zero patterns just inside and just outside each width boundary.

// File: rtl/opmask_ortest.sv
module opmask_ortest #(
  parameter int NREG = 8,
  parameter int MW   = 64,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [MW-1:0] wr_data,
  input  logic          test_vld,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic          w_bit,
  input  logic          pfx,
  output logic          zf,
  output logic          cf,
  output logic          of,
  output logic          sf,
  output logic          af,
  output logic          pf,
  output logic          done
);

  logic [MW-1:0] mreg [NREG];
  logic [MW-1:0] opa, opb, wmask, orv;
  logic [6:0]    width;

  always_comb
    case ({w_bit, pfx})
      2'b00:   width = 7'd16;
      2'b01:   width = 7'd8;
      2'b10:   width = 7'd64;
      default: width = 7'd32;
    endcase

  assign wmask = ~({MW{1'b1}} << width);
  assign opa   = (wr_en && wr_idx == src_a) ? wr_data : mreg[src_a];
  assign opb   = (wr_en && wr_idx == src_b) ? wr_data : mreg[src_b];
  assign orv   = (opa | opb) & wmask;

  always_ff @(posedge clk)
    if (rst) begin
      for (int i = 0; i < NREG; i++) mreg[i] <= '0;
    end else if (wr_en) begin
      mreg[wr_idx] <= wr_data;
    end

  always_ff @(posedge clk)
    if (rst) begin
      {zf, cf, of, sf, af, pf, done} <= '0;
    end else begin
      done <= test_vld;
      if (test_vld) begin
        zf <= (orv == '0);
        cf <= (orv == wmask);
        {of, sf, af, pf} <= '0;
      end
    end

endmodule

module opmask_ortest_chk (
  input logic clk,
  input logic rst,
  input logic test_vld,
  input logic zf,
  input logic cf,
  input logic of,
  input logic sf,
  input logic af,
  input logic pf,
  input logic done
);

  // R5
  quiet_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(of || sf || af || pf));

  // R8
  done_follows_chk: assert property (@(posedge clk) disable iff (rst)
    test_vld |=> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    !test_vld |=> !done);

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !test_vld |=> ($stable(zf) && $stable(cf)));

  // R3
  zero_excl_chk: assert property (@(posedge clk) disable iff (rst)
    zf |-> !cf);

endmodule

bind opmask_ortest opmask_ortest_chk u_chk (
  .clk(clk), .rst(rst), .test_vld(test_vld),
  .zf(zf), .cf(cf), .of(of), .sf(sf), .af(af), .pf(pf), .done(done)
);

// File: tb/opmask_ortest_bench.sv
module opmask_ortest_bench;
  localparam int PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        wr_en = 0, test_vld = 0, w_bit = 0, pfx = 0;
  logic [2:0]  wr_idx = 0, src_a = 0, src_b = 0;
  logic [63:0] wr_data = 0;
  logic        zf, cf, of, sf, af, pf, done;

  logic [63:0] shadow [8];
  int checks = 0, fails = 0;

  opmask_ortest u_opmask_ortest (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .test_vld(test_vld), .src_a(src_a), .src_b(src_b), .w_bit(w_bit), .pfx(pfx),
    .zf(zf), .cf(cf), .of(of), .sf(sf), .af(af), .pf(pf), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] wmask_of(logic w, logic p);
    case ({w, p})
      2'b00:   return 64'h0000_0000_0000_FFFF;
      2'b01:   return 64'h0000_0000_0000_00FF;
      2'b10:   return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0000_0000_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] exp_flags(logic [63:0] a, logic [63:0] b, logic w, logic p);
    logic [63:0] m, r;
    m = wmask_of(w, p);
    r = (a | b) & m;
    return {r == 0, r == m};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic op(bit we, logic [2:0] wi, logic [63:0] wd,
                    bit tv, logic [2:0] a, logic [2:0] b, logic w, logic p, string req);
    logic [1:0] e;
    logic [1:0] prev;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    test_vld = tv; src_a = a; src_b = b; w_bit = w; pfx = p;
    prev = {zf, cf};
    if (we) shadow[wi] = wd;
    e = exp_flags(shadow[a], shadow[b], w, p);
    @(negedge clk);
    wr_en = 0; test_vld = 0;
    if (tv) begin
      check({zf, cf} == e, req, "zf,cf", {zf, cf}, e);
      check(done == 1'b1, "R8", "done after test", done, 1);
      check({of, sf, af, pf} == 0, "R5", "quiet flags", {of, sf, af, pf}, 0);
    end else begin
      check(done == 1'b0, "R8", "done idle", done, 0);
      check({zf, cf} == prev, "R8", "flags hold", {zf, cf}, prev);
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check({zf, cf, of, sf, af, pf, done} == 0, "R1", "outputs after reset",
          {zf, cf, of, sf, af, pf, done}, 0);
    // R1: registers cleared -> every width reports zero
    op(0, 0, 0, 1, 5, 7, 1, 0, "R1");

    // R10 R4: write all ones, 64-bit test sets cf
    op(1, 3, '1, 0, 0, 0, 0, 0, "R10");
    op(0, 0, 0, 1, 3, 0, 1, 0, "R10");
    // R2 R6: upper garbage ignored in each width
    op(1, 1, 64'hAAAA_0000_0000_0000, 0, 0, 0, 0, 0, "R10");
    op(1, 2, 64'h5555_FFFF_FFFF_FF00, 0, 0, 0, 0, 0, "R10");
    op(0, 0, 0, 1, 1, 2, 0, 1, "R6");
    op(0, 0, 0, 1, 1, 2, 0, 0, "R2");
    op(0, 0, 0, 1, 1, 2, 1, 1, "R2");
    op(0, 0, 0, 1, 1, 2, 1, 0, "R2");
    op(1, 4, 64'h0000_0000_0000_00FF, 0, 0, 0, 0, 0, "R10");
    op(0, 0, 0, 1, 4, 4, 0, 1, "R4");
    op(0, 0, 0, 1, 4, 0, 0, 0, "R3");
    op(1, 5, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, 0, "R10");
    op(0, 0, 0, 1, 5, 0, 1, 1, "R6");
    op(0, 0, 0, 1, 5, 3, 1, 1, "R4");

    // R7: a test leaves registers alone
    op(1, 6, 0, 0, 0, 0, 0, 0, "R10");
    op(0, 0, 0, 1, 6, 3, 1, 0, "R7");
    op(0, 0, 0, 1, 6, 6, 1, 0, "R7");

    // R9: same-cycle write and test
    op(1, 6, '1, 1, 6, 0, 1, 0, "R9");
    op(1, 6, 0, 1, 0, 6, 0, 0, "R9");
    op(1, 7, 64'h0000_0000_0000_0080, 1, 7, 7, 0, 1, "R9");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [63:0] d;
      int k;
      k = $urandom_range(0, 5);
      case ($urandom_range(0, 3))
        0: d = '1;
        1: d = 0;
        2: d = wmask_of(1'($urandom), 1'($urandom));
        default: d = {$urandom, $urandom};
      endcase
      op(k < 3, 3'($urandom), d, k != 0 && k != 5, 3'($urandom), 3'($urandom),
         1'($urandom), 1'($urandom), "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule